// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column half of an SDRAM controller's read and write path. A command strobe carries a starting column and the burst settings currently in force. From the next clock on, the block puts out one column address per cycle for each beat of the burst. It also flags the final beat and raises a read-data-valid strobe for every read beat once the CAS latency has passed. Bank and row state, refresh, precharge and the DQ pins are handled elsewhere.

Ordering is either sequential or interleaved. In sequential mode the column counts up and wraps inside a block that is aligned to the burst length. In interleaved mode the low column bits are the start value XOR the beat index. A full-page setting counts up through a whole 256-column row and wraps within that row. It continues until a terminate arrives or a new command replaces it. A command whose settings cannot be honoured raises an error pulse and is dropped.

The beat output is a valid-only stream. The memory cannot stall, so there is no ready and no back-pressure: a beat is presented for exactly one cycle, and the consumer must take it in that cycle. Commands are always accepted in the cycle they are strobed, so the command side has no ready either.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `beat_valid`, `beat_last`, `rd_data_valid` and `cfg_err` are all low.
- R2: A legal command sampled on an edge makes `beat_valid` high in the next cycle, with `beat_col` equal to the command's start column. Beats then follow on consecutive cycles.
- R3: Sequential order (`cfg_ilv`=0) with length L has the low log2(L) column bits count up from the start value modulo L. The column bits above them stay equal to the start column for the whole burst; for example L=4 from 0x42 gives 0x42, 0x43, 0x40, 0x41.
- R4: Interleaved order (`cfg_ilv`=1) with length L has the low log2(L) column bits equal to the start bits XOR the beat index, with the upper bits unchanged; for example L=8 from 0xA5 gives 0xA5, 0xA4, 0xA7, 0xA6, 0xA1, 0xA0, 0xA3, 0xA2.
- R5: Length codes on `cfg_bl` are 0, 1, 2 and 3 for 1, 2, 4 and 8 beats. `beat_last` is high on the final beat only, and `beat_valid` is low in the cycle after it unless a new command was sampled.
- R6: Code 7 on `cfg_bl` with `cfg_ilv`=0 is full page. The column counts up by one per beat, wraps from 255 to 0 in the same row, never ends by itself, and never raises `beat_last`.
- R7: Codes 4, 5 and 6, and code 7 with `cfg_ilv`=1, are illegal. Such a command raises `cfg_err` for one cycle, starting one cycle after it is sampled, starts no burst, and leaves any burst in progress running unchanged.
- R8: `term` sampled high while a beat is presented makes `beat_valid` low in the next cycle, unless a legal command is sampled on the same edge.
- R9: A legal command sampled during a burst replaces it. The next cycle presents the new burst's first beat, and a legal command takes precedence over `term` on the same edge.
- R10: `rd_data_valid` is high in cycle c+N exactly when a read beat was presented in cycle c, where N (1, 2 or 3) is the value on `cfg_cl`. Write beats never raise it.
- R11: `beat_rd` equals the `cmd_rd` value of the command that started the burst being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_rd | input | 1 | 1 = read command, 0 = write command |
| cmd_col | input | 8 | Start column of the burst |
| cfg_bl | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| cfg_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cfg_cl | input | 2 | CAS latency in clocks, 1 to 3 |
| term | input | 1 | Burst terminate |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_col | output | 8 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final beat of a fixed-length burst |
| beat_rd | output | 1 | Current burst is a read |
| rd_data_valid | output | 1 | Read data for a beat issued CAS latency cycles earlier is due |
| cfg_err | output | 1 | The previous command had an illegal burst setting |

## Verification
The latency properties assume that `cfg_cl` holds a value from 1 to 3 and that it stays unchanged while any read beat is still in the latency pipe. This mirrors a mode setting that is written only while the memory is idle. The stimulus therefore changes `cfg_cl` only after at least four idle cycles. The remaining properties assume nothing about the inputs: commands, terminates and illegal codes arrive in any cycle, including back to back and mid-burst. The stimulus exercises those cases, together with a full-page burst that runs past the row end.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } blen_code_e;
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode #(
  parameter int COL_W = 8,
  parameter int BLC_W = 3
) (
  input  logic [BLC_W-1:0] blc,
  input  logic             ilv,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page_mode,
  output logic             illegal
);
  import bcs_pkg::*;

  always_comb begin
    page_mode = (blc == BLC_PAGE);
    illegal   = (blc[BLC_W-1] && !page_mode) || (page_mode && ilv);
    if (page_mode)
      wrap_mask = '1;
    else
      wrap_mask = ~({COL_W{1'b1}} << blc[1:0]);
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic [COL_W-1:0] load_mask,
  input  logic             load_page,
  input  logic             load_ilv,
  input  logic             load_rd,
  input  logic             stop,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_rd
);
  logic             active_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             ilv_q;
  logic             rd_q;
  logic [COL_W-1:0] low_bits;
  logic             final_beat;

  always_comb begin
    if (ilv_q)
      low_bits = start_q ^ idx_q;
    else
      low_bits = start_q + idx_q;
    final_beat = active_q && !page_q && (idx_q == mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      start_q  <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      ilv_q    <= 1'b0;
      rd_q     <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      start_q  <= load_col;
      mask_q   <= load_mask;
      page_q   <= load_page;
      ilv_q    <= load_ilv;
      rd_q     <= load_rd;
    end else if (active_q) begin
      if (stop || final_beat)
        active_q <= 1'b0;
      else
        idx_q <= idx_q + 1'b1;
    end
  end

  assign beat_valid = active_q;
  assign beat_col   = (start_q & ~mask_q) | (low_bits & mask_q);
  assign beat_last  = final_beat;
  assign beat_rd    = rd_q;
endmodule

// File: rtl/bcs_rd_delay.sv
module bcs_rd_delay #(
  parameter int CL_MAX = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid
);
  logic [CL_MAX:1] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[1] <= issue;
      for (int s = 2; s <= CL_MAX; s++)
        pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    for (int s = 1; s <= CL_MAX; s++)
      if (cl == CL_W'(s))
        rd_valid = pipe_q[s];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W  = 8,
  parameter int BLC_W  = 3,
  parameter int CL_MAX = 3,
  parameter int CL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_rd,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [BLC_W-1:0] cfg_bl,
  input  logic             cfg_ilv,
  input  logic [CL_W-1:0]  cfg_cl,
  input  logic             term,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_rd,
  output logic             rd_data_valid,
  output logic             cfg_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_bad;
  logic             start_burst;
  logic             err_q;

  bcs_decode #(.COL_W(COL_W), .BLC_W(BLC_W)) u_dec (
    .blc       (cfg_bl),
    .ilv       (cfg_ilv),
    .wrap_mask (dec_mask),
    .page_mode (dec_page),
    .illegal   (dec_bad)
  );

  assign start_burst = cmd_valid && !dec_bad;

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_burst),
    .load_col   (cmd_col),
    .load_mask  (dec_mask),
    .load_page  (dec_page),
    .load_ilv   (cfg_ilv),
    .load_rd    (cmd_rd),
    .stop       (term),
    .beat_valid (beat_valid),
    .beat_col   (beat_col),
    .beat_last  (beat_last),
    .beat_rd    (beat_rd)
  );

  bcs_rd_delay #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_rdd (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (beat_valid && beat_rd),
    .cl       (cfg_cl),
    .rd_valid (rd_data_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cmd_valid && dec_bad;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 8,
  parameter int BLC_W = 3,
  parameter int CL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_rd,
  input logic [COL_W-1:0] cmd_col,
  input logic [BLC_W-1:0] cfg_bl,
  input logic             cfg_ilv,
  input logic [CL_W-1:0]  cfg_cl,
  input logic             term,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_last,
  input logic             beat_rd,
  input logic             rd_data_valid,
  input logic             cfg_err
);
  logic bad_cmd;
  logic in_page_q;

  assign bad_cmd = cmd_valid &&
                   ((cfg_bl inside {3'd4, 3'd5, 3'd6}) || (cfg_bl == 3'd7 && cfg_ilv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_page_q <= 1'b0;
    else if (cmd_valid && !bad_cmd) in_page_q <= (cfg_bl == 3'd7);
  end

  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !bad_cmd |=> beat_valid && beat_col == $past(cmd_col) && beat_rd == $past(cmd_rd));

  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last && !term |=> beat_valid);

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last && !cmd_valid |=> !beat_valid);

  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && in_page_q |-> !beat_last);

  p_bad_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> cfg_err);

  p_bad_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd && !beat_valid |=> !beat_valid);

  p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && term && !cmd_valid |=> !beat_valid);

  p_cl1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cl == 2'd1 |-> rd_data_valid == $past(beat_valid && beat_rd, 1));

  p_cl2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cl == 2'd2 && $stable(cfg_cl) |-> rd_data_valid == $past(beat_valid && beat_rd, 2));

  p_cl3_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cl == 2'd3 && $stable(cfg_cl) && $past(cfg_cl) == $past(cfg_cl, 2)
      |-> rd_data_valid == $past(beat_valid && beat_rd, 3));

  p_cl_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cl != 2'd0);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .BLC_W(BLC_W), .CL_W(CL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_col(cmd_col),
  .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .cfg_cl(cfg_cl), .term(term),
  .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last), .beat_rd(beat_rd),
  .rd_data_valid(rd_data_valid), .cfg_err(cfg_err)
);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_rd = 1'b0;
  logic [7:0] cmd_col = 8'h00;
  logic [2:0] cfg_bl = 3'd0;
  logic       cfg_ilv = 1'b0;
  logic [1:0] cfg_cl = 2'd3;
  logic       term = 1'b0;
  logic       beat_valid, beat_last, beat_rd, rd_data_valid, cfg_err;
  logic [7:0] beat_col;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_col(cmd_col),
    .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .cfg_cl(cfg_cl), .term(term),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last), .beat_rd(beat_rd),
    .rd_data_valid(rd_data_valid), .cfg_err(cfg_err)
  );

  // Behavioural reference: state describes the outputs of the current cycle.
  bit m_act = 0, m_rd = 0, m_ilv = 0, m_page = 0, m_err = 0;
  int m_start = 0, m_len = 1, m_k = 0;
  bit exp_rd[64];
  int cyc = 0;

  function automatic int ref_col();
    int off = m_start % m_len;
    int base = m_start - off;
    if (m_ilv) return base + (off ^ m_k);
    return base + ((off + m_k) % m_len);
  endfunction

  function automatic bit ref_last();
    return m_act && !m_page && (m_k == m_len - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_err = 0; m_k = 0;
      for (int i = 0; i < 64; i++) exp_rd[i] = 0;
    end else begin
      bit legal;
      if (m_act && m_rd) exp_rd[(cyc + int'(cfg_cl)) % 64] = 1;
      legal = cmd_valid && (cfg_bl <= 3 || (cfg_bl == 7 && !cfg_ilv));
      m_err = cmd_valid && !legal;
      if (legal) begin
        m_act = 1; m_k = 0; m_start = int'(cmd_col); m_rd = cmd_rd;
        m_ilv = cfg_ilv; m_page = (cfg_bl == 7);
        m_len = m_page ? 256 : (1 << cfg_bl);
      end else if (m_act) begin
        if (term || ref_last()) m_act = 0;
        else m_k = m_k + 1;
      end
    end
    cyc = cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R8 R9 beat_valid", beat_valid, m_act);
      chk("R7 cfg_err", cfg_err, m_err);
      chk("R10 rd_data_valid", rd_data_valid, exp_rd[cyc % 64]);
      exp_rd[cyc % 64] = 0;
      if (m_act) begin
        chk(m_ilv ? "R4 beat_col" : (m_page ? "R6 beat_col" : "R3 beat_col"), beat_col, ref_col());
        chk(m_page ? "R6 beat_last" : "R5 beat_last", beat_last, ref_last());
        chk("R11 beat_rd", beat_rd, m_rd);
      end else begin
        chk("R5 beat_last idle", beat_last, 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input bit rd, input int col, input int bl, input bit ilv);
    @(negedge clk);
    cmd_valid = 1; cmd_rd = rd; cmd_col = 8'(col); cfg_bl = 3'(bl); cfg_ilv = ilv;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_term();
    @(negedge clk); term = 1;
    @(negedge clk); term = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle(4);
    // R1: quiet outputs in reset
    chk("R1 reset valid", beat_valid, 0);
    chk("R1 reset rd", rd_data_valid, 0);
    chk("R1 reset err", cfg_err, 0);
    rst_n = 1;
    idle(1);
    chk("R1 after reset valid", beat_valid, 0);
    // R3 sequential BL4 with upper bits, read at CL3 (R10)
    issue(1, 'h42, 2, 0); idle(8);
    // R4 interleaved BL8
    issue(1, 'hA5, 3, 1); idle(12);
    // R5 BL1 and interleaved BL2 writes (no rd strobe, R10 R11)
    issue(0, 'h10, 0, 0); idle(2);
    issue(0, 'h33, 1, 1); idle(6);
    // R10 latency 1 then 2
    cfg_cl = 2'd1; idle(2);
    issue(1, 'h07, 3, 0); idle(12);
    cfg_cl = 2'd2; idle(2);
    issue(1, 'hFF, 1, 0); idle(8);
    issue(1, 'h6C, 3, 1); idle(12);
    cfg_cl = 2'd3; idle(2);
    // R6 full page across row end, then R8 terminate
    issue(1, 'hFD, 7, 0); idle(262);
    pulse_term(); idle(6);
    // R7 illegal settings while idle
    issue(1, 'h00, 7, 1); idle(3);
    issue(0, 'h20, 5, 0); idle(3);
    issue(0, 'h20, 4, 1); idle(3);
    issue(0, 'h20, 6, 0); idle(3);
    // R7 illegal command during a burst leaves it running
    issue(1, 'h58, 3, 0); idle(2);
    issue(1, 'h99, 6, 0); idle(10);
    // R9 replacement mid burst
    issue(1, 'h10, 3, 0); idle(2);
    issue(0, 'h81, 2, 1); idle(8);
    // R8 terminate a fixed burst
    issue(1, 'hC4, 3, 1); idle(1);
    pulse_term(); idle(6);
    // R9 command and terminate on the same edge: command wins
    issue(1, 'h30, 3, 0); idle(1);
    @(negedge clk);
    term = 1; cmd_valid = 1; cmd_rd = 0; cmd_col = 8'h4E; cfg_bl = 3'd2; cfg_ilv = 0;
    @(negedge clk);
    term = 0; cmd_valid = 0;
    idle(8);
    // back-to-back commands every cycle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_rd = i[0]; cmd_col = 8'(i * 37); cfg_bl = 3'(i % 4); cfg_ilv = i[1];
    end
    @(negedge clk); cmd_valid = 0;
    idle(14);
    finish_run();
  end
endmodule